// File: doc/BRIEF.md
# Monochrome NTSC Field Sampling Timing Generator

This block decides when a monochrome NTSC video signal should be digitized. It runs from a 50 MHz system clock and is driven by the vertical sync, the horizontal sync and the odd/even indicator of an external sync separator. From these inputs it produces four things:

- a free-running 12.5 MHz sample enable;
- a strobe marking the enables that fall inside the active picture;
- the horizontal and vertical coordinates of each such sample;
- a one-cycle pulse once the last sample of a field has been taken.

All windows are fixed cycle counts. After a vertical sync the block waits 55,562 cycles, which covers the blanking lines at the top of the field. After that, each accepted horizontal sync opens a line. The block waits 470 cycles (9.4 us) and then takes 640 samples, one every 4 cycles. It accepts 242 such lines per field. The trailing half line and any later syncs are ignored until the next vertical sync. The divide-by-4 enable is re-phased at every accepted line start, so the first sample of a line falls exactly 470 cycles after the sync edge. The 470 + 2560 cycles of a line fit inside the 3175-cycle (63.5 us) line period.

A downstream pixel capture stage uses the valid strobe as its write enable and the two indices as its address. It uses the field-done pulse to start processing the field.

Top module: `ntsc_field_sampler`

## Requirements
- R1: `smp_en_o` is a one-cycle pulse every DIV (4) cycles. It runs whether or not a line is active, and its first pulse is in the cycle right after the last reset edge.
- R2: A rising edge of `vsync_i` sampled at clock edge v arms line acceptance only after FIELD_SKIP (55,562) further edges. A rising edge of `hsync_i` sampled at any edge up to and including v+FIELD_SKIP is ignored.
- R3: When a rising edge of `hsync_i` sampled at edge h is accepted as a line start, the first `smp_valid_o` of that line is high in the cycle after edge h+LINE_DELAY (470). `smp_en_o` is re-phased so that it is also high in that cycle.
- R4: Each accepted line gives exactly SAMPLES (640) `smp_valid_o` pulses, each coinciding with `smp_en_o` and spaced DIV cycles apart. `px_idx_o` reads 0, 1, ... SAMPLES-1 on them, and `smp_valid_o` is low at every other time.
- R5: Accepted lines are numbered 0 to LINES-1 (241) in order of arrival, and `ln_idx_o` carries that number with every valid sample. After LINES lines, further horizontal syncs are ignored until the next vertical sync.
- R6: `field_done_o` is high for exactly one cycle: the cycle right after the valid sample with px_idx SAMPLES-1 on line LINES-1.
- R7: A rising edge of `hsync_i` that arrives while a line is in its delay or sampling window is ignored and does not disturb that line.
- R8: A rising edge of `vsync_i` at any time ends the current line at once with no further valid samples, resets the line count to 0 and restarts the field skip wait.
- R9: `field_odd_o` takes the value of `field_odd_i` at each vertical sync rising edge and holds it otherwise. It is 0 after reset.
- R10: After reset, `smp_valid_o`, `field_done_o` and `field_odd_o` are 0, and no horizontal sync is accepted before the first vertical sync.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 50 MHz system clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vsync_i | input | 1 | Vertical sync from the sync separator, active high; its rising edge starts a field |
| hsync_i | input | 1 | Horizontal sync from the sync separator, active high; its rising edge starts a line |
| field_odd_i | input | 1 | Odd/even field indicator from the sync separator |
| smp_en_o | output | 1 | 12.5 MHz sample enable (one cycle in DIV) |
| smp_valid_o | output | 1 | High on enables that fall inside the active picture |
| px_idx_o | output | PX_W (10) | Horizontal sample index, meaningful while `smp_valid_o` is high |
| ln_idx_o | output | LN_W (8) | Valid line index, meaningful while `smp_valid_o` is high |
| field_done_o | output | 1 | One-cycle pulse after the final sample of a field |
| field_odd_o | output | 1 | Field parity latched at the last vertical sync |

## Verification
The hardest situations to reach are the exact arming boundary and the collisions between syncs and an open line. These include a horizontal sync landing on the last ignored cycle of the field skip, one arriving mid-line, and a vertical sync arriving while samples are being taken. At the default counts a single field is far longer than the bench may run. The bench therefore shrinks FIELD_SKIP, LINE_DELAY, SAMPLES and LINES through the top's parameters. It then places syncs at computed cycle offsets from the vertical sync: one on the boundary edge, one in the middle of a line, and a vertical sync that cuts a line short. A behavioural model tracks edge indices and predicts every output on every cycle.

// File: rtl/ntsc_smp_pkg.sv
`timescale 1ns/1ps
// Package: shared types of the NTSC field sampler.
// Assumes nothing beyond IEEE 1800-2017.
package ntsc_smp_pkg;

    // Phase of the per-line window sequence
    typedef enum logic [1:0] {
        LN_IDLE   = 2'd0,   // waiting for an accepted horizontal sync
        LN_DELAY  = 2'd1,   // counting the blanking delay after the sync
        LN_SAMPLE = 2'd2    // taking samples on the divided enable
    } line_phase_e;

endpackage

// File: rtl/ntsc_edge_det.sv
`timescale 1ns/1ps
// Module: ntsc_edge_det
// Flags a rising edge of a level input: the output is high in the cycle
// where the input is high and was low at the previous clock edge.
// Assumes the input is already synchronous to clk.
module ntsc_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    output logic rise_o
);

    logic lvl_q;

    // Remember the level seen at the previous edge
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= 1'b0;
        else        lvl_q <= lvl_i;
    end

    // Rising edge: high now, low before
    always_comb rise_o = lvl_i & ~lvl_q;

endmodule

// File: rtl/ntsc_field_gate.sv
`timescale 1ns/1ps
// Module: ntsc_field_gate
// Owns the field-level state: the skip wait after vertical sync, the
// count of completed lines and the end-of-field pulse. A vertical sync
// edge always wins over a line completion in the same cycle.
// Assumes line_done_i is a single-cycle pulse per finished line.
module ntsc_field_gate #(
    parameter int SKIP_CYC  = 55562,
    parameter int NUM_LINES = 242,
    parameter int LN_W      = $clog2(NUM_LINES + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            vs_rise_i,
    input  logic            line_done_i,
    output logic            accept_o,
    output logic            skipping_o,
    output logic [LN_W-1:0] ln_idx_o,
    output logic            done_o
);

    localparam int SK_W = (SKIP_CYC > 1) ? $clog2(SKIP_CYC) : 1;
    localparam logic [SK_W-1:0] SK_LAST   = SK_W'(SKIP_CYC - 1);
    localparam logic [LN_W-1:0] LN_LAST   = LN_W'(NUM_LINES - 1);
    localparam logic [LN_W-1:0] LN_LIMIT  = LN_W'(NUM_LINES);

    logic [SK_W-1:0] skip_cnt;
    logic            skipping;
    logic            armed;
    logic [LN_W-1:0] ln_cnt;
    logic            done_q;

    // Skip counter: restart on vertical sync, arm when the wait has elapsed
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            skip_cnt <= '0;
            skipping <= 1'b0;
            armed    <= 1'b0;
        end else if (vs_rise_i) begin
            skip_cnt <= '0;
            skipping <= 1'b1;
            armed    <= 1'b0;
        end else if (skipping) begin
            if (skip_cnt == SK_LAST) begin
                skipping <= 1'b0;
                armed    <= 1'b1;
            end else begin
                skip_cnt <= skip_cnt + 1'b1;
            end
        end
    end

    // Line counter and field-done pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ln_cnt <= '0;
            done_q <= 1'b0;
        end else if (vs_rise_i) begin
            ln_cnt <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= line_done_i && (ln_cnt == LN_LAST);
            if (line_done_i) ln_cnt <= ln_cnt + 1'b1;
        end
    end

    // New lines are welcome only when armed and the field is not full
    always_comb accept_o = armed && (ln_cnt < LN_LIMIT);

    assign skipping_o = skipping;
    assign ln_idx_o   = ln_cnt;
    assign done_o     = done_q;

    // R2: while the skip wait runs, no line may be accepted
    a_r2_no_accept_in_skip: assert property (@(posedge clk) disable iff (!rst_n)
        skipping |-> !accept_o);

    // R5: the line count never passes the field size
    a_r5_line_bound: assert property (@(posedge clk) disable iff (!rst_n)
        ln_cnt <= LN_LIMIT);

    // R6: field-done lasts a single cycle
    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

endmodule

// File: rtl/ntsc_line_sampler.sv
`timescale 1ns/1ps
// Module: ntsc_line_sampler
// Generates the divided sample enable and runs the per-line window:
// a fixed delay after an accepted sync, then SAMPLES samples on the
// enable. The divider is re-phased at each line start so that its tick
// lands exactly LINE_DELAY cycles later.
// Assumes start_i is only raised while busy_o is low.
module ntsc_line_sampler
    import ntsc_smp_pkg::*;
#(
    parameter int LINE_DELAY = 470,
    parameter int SAMPLES    = 640,
    parameter int DIV        = 4,
    parameter int PX_W       = $clog2(SAMPLES)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic            abort_i,
    output logic            busy_o,
    output logic            smp_en_o,
    output logic            smp_valid_o,
    output logic [PX_W-1:0] px_o,
    output logic            line_end_o
);

    localparam int DV_W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam int DL_W = (LINE_DELAY > 1) ? $clog2(LINE_DELAY) : 1;
    localparam logic [DV_W-1:0] DV_LAST = DV_W'(DIV - 1);
    localparam logic [DV_W-1:0] DV_ALIGN = DV_W'((DIV - (LINE_DELAY % DIV)) % DIV);
    localparam logic [DL_W-1:0] DL_LAST = DL_W'(LINE_DELAY - 1);
    localparam logic [PX_W-1:0] PX_LAST = PX_W'(SAMPLES - 1);

    line_phase_e     phase;
    logic [DV_W-1:0] div_cnt;
    logic [DL_W-1:0] dly_cnt;
    logic [PX_W-1:0] px_cnt;
    logic            tick;

    // The enable is the divider sitting at zero
    always_comb tick = (div_cnt == '0);

    // Free-running divider, re-phased at a line start
    always_ff @(posedge clk) begin
        if (!rst_n)                 div_cnt <= '0;
        else if (start_i)           div_cnt <= DV_ALIGN;
        else if (div_cnt == DV_LAST) div_cnt <= '0;
        else                        div_cnt <= div_cnt + 1'b1;
    end

    // Line window sequence: idle, delay, sample
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= LN_IDLE;
            dly_cnt <= '0;
            px_cnt  <= '0;
        end else if (abort_i) begin
            phase   <= LN_IDLE;
        end else begin
            unique case (phase)
                LN_IDLE: begin
                    if (start_i) begin
                        phase   <= LN_DELAY;
                        dly_cnt <= '0;
                    end
                end
                LN_DELAY: begin
                    if (dly_cnt == DL_LAST) begin
                        phase  <= LN_SAMPLE;
                        px_cnt <= '0;
                    end else begin
                        dly_cnt <= dly_cnt + 1'b1;
                    end
                end
                LN_SAMPLE: begin
                    if (tick) begin
                        if (px_cnt == PX_LAST) phase  <= LN_IDLE;
                        else                   px_cnt <= px_cnt + 1'b1;
                    end
                end
                default: phase <= LN_IDLE;
            endcase
        end
    end

    // Output decode
    always_comb begin
        busy_o      = (phase != LN_IDLE);
        smp_en_o    = tick;
        smp_valid_o = (phase == LN_SAMPLE) && tick;
        line_end_o  = (phase == LN_SAMPLE) && tick && (px_cnt == PX_LAST);
    end
    assign px_o = px_cnt;

    // R4: a valid sample never carries an index outside the line
    a_r4_px_bound: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid_o |-> (px_o <= PX_LAST));

    // R4: after a non-final sample the line is still open
    a_r4_line_continues: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid_o && (px_o != PX_LAST) && !abort_i) |=> busy_o);

    // R7: a line start is only given while idle
    a_r7_start_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !busy_o);

endmodule

// File: rtl/ntsc_field_sampler.sv
`timescale 1ns/1ps
// Module: ntsc_field_sampler (top)
// Sampling timing generator for monochrome NTSC: skips the blanking
// lines after vertical sync, then opens a fixed delay and sample window
// after each accepted horizontal sync, and reports coordinates.
// Assumes sync inputs are clean, active-high and synchronous to clk.
module ntsc_field_sampler #(
    parameter int FIELD_SKIP = 55562,
    parameter int LINE_DELAY = 470,
    parameter int SAMPLES    = 640,
    parameter int LINES      = 242,
    parameter int DIV        = 4,
    parameter int PX_W       = $clog2(SAMPLES),
    parameter int LN_W       = $clog2(LINES + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            vsync_i,
    input  logic            hsync_i,
    input  logic            field_odd_i,
    output logic            smp_en_o,
    output logic            smp_valid_o,
    output logic [PX_W-1:0] px_idx_o,
    output logic [LN_W-1:0] ln_idx_o,
    output logic            field_done_o,
    output logic            field_odd_o
);

    localparam logic [PX_W-1:0] PX_LAST = PX_W'(SAMPLES - 1);
    localparam logic [LN_W-1:0] LN_LAST = LN_W'(LINES - 1);

    logic vs_rise, hs_rise;
    logic accept, skipping, busy, line_end, line_start;
    logic odd_q;

    ntsc_edge_det i_vs_edge (.clk(clk), .rst_n(rst_n), .lvl_i(vsync_i), .rise_o(vs_rise));
    ntsc_edge_det i_hs_edge (.clk(clk), .rst_n(rst_n), .lvl_i(hsync_i), .rise_o(hs_rise));

    ntsc_field_gate #(
        .SKIP_CYC (FIELD_SKIP),
        .NUM_LINES(LINES),
        .LN_W     (LN_W)
    ) i_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .vs_rise_i  (vs_rise),
        .line_done_i(line_end),
        .accept_o   (accept),
        .skipping_o (skipping),
        .ln_idx_o   (ln_idx_o),
        .done_o     (field_done_o)
    );

    // A line starts on a sync edge when armed, idle and not pre-empted
    always_comb line_start = hs_rise && accept && !busy && !vs_rise;

    ntsc_line_sampler #(
        .LINE_DELAY(LINE_DELAY),
        .SAMPLES   (SAMPLES),
        .DIV       (DIV),
        .PX_W      (PX_W)
    ) i_line (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (line_start),
        .abort_i    (vs_rise),
        .busy_o     (busy),
        .smp_en_o   (smp_en_o),
        .smp_valid_o(smp_valid_o),
        .px_o       (px_idx_o),
        .line_end_o (line_end)
    );

    // Field parity captured at each vertical sync edge
    always_ff @(posedge clk) begin
        if (!rst_n)       odd_q <= 1'b0;
        else if (vs_rise) odd_q <= field_odd_i;
    end
    assign field_odd_o = odd_q;

    // R6: field-done follows the last sample of the last line
    a_r6_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        field_done_o |-> ($past(smp_valid_o) && ($past(px_idx_o) == PX_LAST)
                          && ($past(ln_idx_o) == LN_LAST)));

    // R9: parity changes only through a vertical sync edge
    a_r9_parity_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !vs_rise |=> $stable(field_odd_o));

    // R2: no sample is valid while the field skip runs
    a_r2_quiet_in_skip: assert property (@(posedge clk) disable iff (!rst_n)
        skipping |-> !smp_valid_o);

    // R8: a vertical sync edge closes any open line
    a_r8_abort_line: assert property (@(posedge clk) disable iff (!rst_n)
        vs_rise |=> !smp_valid_o);

endmodule

// File: tb/test_ntsc_field_sampler.sv
`timescale 1ns/1ps
// Bench: a behavioural model tracks edge indices and predicts every
// output; it is compared at each falling clock edge.
module test_ntsc_field_sampler;

    localparam int FS   = 40;
    localparam int LD   = 10;
    localparam int SM   = 8;
    localparam int LN   = 4;
    localparam int DV   = 4;
    localparam int PXW  = $clog2(SM);
    localparam int LNW  = $clog2(LN + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic vsync = 1'b0, hsync = 1'b0, fodd = 1'b0;
    logic smp_en, smp_valid, fdone, fodd_o;
    logic [PXW-1:0] px;
    logic [LNW-1:0] ln;

    int tests = 0, fails = 0;

    always #10 clk = ~clk;

    ntsc_field_sampler #(
        .FIELD_SKIP(FS), .LINE_DELAY(LD), .SAMPLES(SM), .LINES(LN), .DIV(DV)
    ) i_ntsc_field_sampler (
        .clk(clk), .rst_n(rst_n), .vsync_i(vsync), .hsync_i(hsync),
        .field_odd_i(fodd), .smp_en_o(smp_en), .smp_valid_o(smp_valid),
        .px_idx_o(px), .ln_idx_o(ln), .field_done_o(fdone), .field_odd_o(fodd_o)
    );

    // ---------------- reference model ----------------
    int n = 0;
    int since_v = -1, ls = -1, ld = 0, anchor = 0;
    bit pv = 0, ph = 0, m_done = 0, m_odd = 0;

    function automatic int modp(input int a, input int b);
        return ((a % b) + b) % b;
    endfunction

    always @(posedge clk) begin
        bit vse, hse, in_line, last, armed;
        n = n + 1;
        if (!rst_n) begin
            since_v = -1; ls = -1; ld = 0; anchor = n;
            pv = 0; ph = 0; m_done = 0; m_odd = 0;
        end else begin
            vse = vsync && !pv;
            hse = hsync && !ph;
            m_done = 0;
            in_line = (ls >= 0);
            last = (ls >= 0) && ((n - 1 - ls - LD) == (SM - 1) * DV);
            if (vse) begin
                since_v = 0; ls = -1; ld = 0; m_odd = fodd;
            end else begin
                armed = (since_v >= FS);
                if (since_v >= 0 && since_v < 1000000) since_v = since_v + 1;
                if (last) begin
                    ld = ld + 1; ls = -1;
                    if (ld == LN) m_done = 1;
                end else if (hse && armed && !in_line && ld < LN) begin
                    ls = n; anchor = n + LD;
                end
            end
            pv = vsync; ph = hsync;
        end
    end

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", what, act, exp, $time);
        end
    endtask

    // Per-cycle comparison away from the active edge
    int valid_seen = 0, done_seen = 0;
    always @(negedge clk) begin
        bit e_tick, e_valid;
        int k;
        if (rst_n) begin
            e_tick = (modp(n - anchor, DV) == 0);
            k = n - ls - LD;
            e_valid = (ls >= 0) && (k >= 0) && (k % DV == 0) && (k / DV < SM);
            chk(smp_en == e_tick, "R1 sample enable", smp_en, e_tick);
            chk(smp_valid == e_valid, "R2/R3/R4/R7/R8/R10 sample valid", smp_valid, e_valid);
            if (e_valid && smp_valid) begin
                chk(px == PXW'(k / DV), "R4 px index", px, k / DV);
                chk(ln == LNW'(ld), "R5 line index", ln, ld);
            end
            chk(fdone == m_done, "R6 field done", fdone, m_done);
            chk(fodd_o == m_odd, "R9 field parity", fodd_o, m_odd);
            if (smp_valid) valid_seen++;
            if (fdone) done_seen++;
        end
    end

    // ---------------- stimulus ----------------
    task automatic wait_cyc(input int c);
        repeat (c) @(posedge clk);
        #5;
    endtask

    task automatic pulse_h;
        hsync = 1'b1; wait_cyc(3); hsync = 1'b0;
    endtask

    task automatic summary;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        #4_000_000;
        tests++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        wait_cyc(4);
        // R10: reset state visible while reset is held
        chk(smp_valid == 1'b0, "R10 reset valid", smp_valid, 0);
        chk(fdone == 1'b0, "R10 reset done", fdone, 0);
        chk(fodd_o == 1'b0, "R10 reset parity", fodd_o, 0);
        rst_n = 1'b1;
        wait_cyc(5);
        // R10: sync before any vertical sync is ignored
        pulse_h(); wait_cyc(60);
        chk(valid_seen == 0, "R10 no line before vsync", valid_seen, 0);

        // Field A (even): boundary hsync at v+FS is ignored (R2), mid-line syncs (R7)
        vsync = 1'b1; fodd = 1'b0; wait_cyc(2); vsync = 1'b0;
        wait_cyc(FS - 2);
        pulse_h(); wait_cyc(47);
        chk(valid_seen == 0, "R2 boundary hsync ignored", valid_seen, 0);
        for (int i = 0; i < 6; i++) begin
            pulse_h(); wait_cyc(17);
            pulse_h(); wait_cyc(27);
        end
        wait_cyc(20);
        chk(valid_seen == LN * SM, "R5 samples in field A", valid_seen, LN * SM);
        chk(done_seen == 1, "R6 done count field A", done_seen, 1);

        // Field B (odd): vertical sync cuts a line short (R8)
        vsync = 1'b1; fodd = 1'b1; wait_cyc(2); vsync = 1'b0;
        wait_cyc(60);
        pulse_h(); wait_cyc(20);
        chk(fodd_o == 1'b1, "R9 parity latched odd", fodd_o, 1);
        vsync = 1'b1; fodd = 1'b0; wait_cyc(2); vsync = 1'b0; fodd = 1'b1;
        wait_cyc(30);
        chk(fodd_o == 1'b0, "R9 parity held after input change", fodd_o, 0);

        // Field C: full field after the abort
        valid_seen = 0;
        wait_cyc(20);
        for (int i = 0; i < 5; i++) begin
            pulse_h(); wait_cyc(47);
        end
        wait_cyc(20);
        chk(valid_seen == LN * SM, "R5/R8 samples in field C", valid_seen, LN * SM);
        chk(done_seen == 2, "R6 done count total", done_seen, 2);
        summary();
    end

endmodule